// File: doc/BRIEF.md
# Indexed Block-Transfer SMBus Configuration Slave

This block is a slave on a two-wire SMBus that gives a host access to a small file of nine 8-bit configuration registers. A system clock, much faster than the bus clock, oversamples SCL and SDA. The block finds start and stop conditions as SDA edges while SCL is high. It pulls SDA low through an open-drain enable, either to acknowledge a byte or to send a zero bit.

A host write carries a start index, a byte count and then that many data bytes. The data bytes land in consecutive registers. A host read first sets the index with a short write, issues a repeated start and addresses the block for reading. The block then returns a byte count taken from its count register, followed by register contents from the index onward, for as long as the host acknowledges. The register file drives six output-enable lines, a mode-override enable with a two-bit override mode, and the read-count value to neighbouring logic. It also holds fixed identification values and shows two strap inputs as read-only bits.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, out_en is 6'b111111, pll_sw_en is 0, pll_sw_mode is 2'b11, rd_count is 8 and sda_oe is 0.
- R2: The block acknowledges only the 7-bit address 1101100 (address byte 0xD8 for write, 0xD9 for read). For any other address it leaves SDA released during the acknowledge bit and on every later bit until the next start, and it writes nothing.
- R3: A write transfer is address+W, index N, count X, then data bytes. The block acknowledges each of these bytes and stores data byte k into register N+k.
- R4: Data bytes beyond the count X of the current write are not acknowledged and change no register.
- R5: After a repeated start with address+R, the block sends the byte count (register 8 bits 4:0, upper bits 0), then registers N, N+1, and so on, MSB first. It stops driving SDA once the host answers a byte with NACK.
- R6: An index above 8 reads as 0x00. A data byte written there is acknowledged and discarded.
- R7: Register 0: bits 7:6 read the strap_mode input, bit 3 is writable and drives pll_sw_en, bits 2:1 are writable and drive pll_sw_mode, bits 5:4 read 0 and bit 0 reads 1.
- R8: Register 1 bits 1,2,5,6 drive out_en[0..3] and register 2 bits 1,2 drive out_en[4..5]. All these bits are writable and reset to 1. The other bits of register 1 read 1. In register 2, bits 3 and 0 read 1 and bits 7:4 read 0.
- R9: Registers 3, 4 and 7 read 0x00. Register 5 reads {revision ID, vendor ID 0001}, which is 0x01 by default. Register 6 reads 0xFB. Writes to these registers have no effect.
- R10: Register 8 bits 4:0 are writable, reset to 8 and drive rd_count. Bits 7:5 read 0.
- R11: The block never changes SDA while SCL is high, and it never drives SDA while idle or ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_mode | input | 2 | Strap value shown in register 0 bits 7:6 |
| out_en | output | 6 | Per-output enable bits |
| pll_sw_en | output | 1 | Software override enable for the loop mode |
| pll_sw_mode | output | 2 | Software loop-mode value |
| rd_count | output | 5 | Byte count returned at the start of a read |

## Verification
The checker watches four things on every cycle. SDA never moves while the synchronized SCL is high. The driver stays released whenever the block is idle or ignoring the bus. The outputs change only in the cycle after a register write, and a write aimed beyond the register file leaves every output unchanged. It also checks the reset values. Only the bench's bus transactions can show the rest: which address is accepted, the ordering of index, count and data, NACK of surplus bytes, the content of each register including the read-only and reserved bits, and the count byte that opens each read.

// File: rtl/smb_cfg_pkg.sv
// Package: shared phase encoding and register-map constants for the
// SMBus configuration slave. Assumes a nine-entry register file.
package smb_cfg_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_TX,
        PH_IGNORE
    } phase_t;

    localparam int REG_COUNT = 9;
    localparam int IDX_W     = 8;
    localparam int OUT_W     = 6;
    localparam int CNT_W     = 5;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_ENA   = 1;
    localparam int IDX_ENB   = 2;
    localparam int IDX_IDREV = 5;
    localparam int IDX_DEV   = 6;
    localparam int IDX_CNT   = 8;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL and SDA into the system clock and flags SCL edges,
// start and stop conditions. Assumes the system clock is many times the
// bus clock so each bus phase spans several samples.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Shift both lines through the synchronizer chain and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_proto.sv
// Byte and protocol engine: shifts bits, acknowledges, decodes the
// address/index/count/data sequence and serves reads. Assumes the host
// keeps SDA stable while SCL is high except for start and stop.
module smb_proto
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       count_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe,
    output logic             bus_quiet
);
    phase_t           phase;
    logic [3:0]       bit_cnt;
    logic             ack_slot;
    logic [7:0]       shreg;
    logic [7:0]       tx_byte;
    logic             tx_first;
    logic             host_nack;
    logic [7:0]       wr_left;
    logic [IDX_W-1:0] idx;

    // Bus state machine: bit counting, acknowledge slots and byte decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            ack_slot  <= 1'b0;
            shreg     <= '0;
            tx_byte   <= '0;
            tx_first  <= 1'b0;
            host_nack <= 1'b0;
            wr_left   <= '0;
            idx       <= '0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase    <= PH_ADDR;
                bit_cnt  <= '0;
                ack_slot <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                ack_slot <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (phase != PH_IDLE && phase != PH_IGNORE) begin
                if (scl_rise) begin
                    if (!ack_slot && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ack_slot) begin
                        host_nack <= sda_s;
                    end
                end else if (scl_fall) begin
                    if (ack_slot) begin
                        ack_slot <= 1'b0;
                        bit_cnt  <= '0;
                        if (phase == PH_TX) begin
                            if (host_nack) begin
                                phase  <= PH_IGNORE;
                                sda_oe <= 1'b0;
                            end else if (tx_first) begin
                                tx_first <= 1'b0;
                                tx_byte  <= count_byte;
                                sda_oe   <= ~count_byte[7];
                            end else begin
                                tx_byte <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                if (idx != '1) idx <= idx + 1'b1;
                            end
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if (bit_cnt == 4'd8) begin
                        ack_slot <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe   <= 1'b1;
                                    tx_first <= 1'b1;
                                    phase    <= shreg[0] ? PH_TX : PH_INDEX;
                                end else begin
                                    sda_oe <= 1'b0;
                                    phase  <= PH_IGNORE;
                                end
                            end
                            PH_INDEX: begin
                                idx    <= shreg;
                                sda_oe <= 1'b1;
                                phase  <= PH_COUNT;
                            end
                            PH_COUNT: begin
                                wr_left <= shreg;
                                sda_oe  <= 1'b1;
                                phase   <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                if (wr_left != 8'd0) begin
                                    sda_oe  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= shreg;
                                    wr_left <= wr_left - 8'd1;
                                    if (idx != '1) idx <= idx + 1'b1;
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (phase == PH_TX) begin
                        sda_oe <= ~tx_byte[3'd7 - bit_cnt[2:0]];
                    end
                end
            end
        end
    end

    assign rd_idx    = idx;
    assign bus_quiet = (phase == PH_IDLE) || (phase == PH_IGNORE);
endmodule

// File: rtl/smb_cfg_regs.sv
// Nine-entry configuration register file. Only bits named writable are
// stored; all other bits read fixed values or the strap input. Assumes
// write strobes last one cycle.
module smb_cfg_regs
    import smb_cfg_pkg::*;
#(
    parameter logic [3:0] REV_ID  = 4'h0,
    parameter logic [3:0] VEND_ID = 4'h1,
    parameter logic [7:0] DEV_ID  = 8'hFB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       strap_mode,
    output logic [7:0]       rd_data,
    output logic [OUT_W-1:0] out_en,
    output logic             pll_sw_en,
    output logic [1:0]       pll_sw_mode,
    output logic [CNT_W-1:0] rd_count
);
    localparam int FLAT_W = REG_COUNT * 8;

    // Writable bit positions of each register.
    function automatic logic [7:0] wmask(input int i);
        case (i)
            IDX_CTRL: return 8'h0E;
            IDX_ENA:  return 8'h66;
            IDX_ENB:  return 8'h06;
            IDX_CNT:  return 8'h1F;
            default:  return 8'h00;
        endcase
    endfunction

    // Reset value of writable bits merged with fixed read values.
    function automatic logic [7:0] base_val(input int i);
        case (i)
            IDX_CTRL:  return 8'h07;
            IDX_ENA:   return 8'hFF;
            IDX_ENB:   return 8'h0F;
            IDX_IDREV: return {REV_ID, VEND_ID};
            IDX_DEV:   return DEV_ID;
            IDX_CNT:   return 8'h08;
            default:   return 8'h00;
        endcase
    endfunction

    logic [FLAT_W-1:0] cur_flat;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [7:0] WM   = wmask(g);
        localparam logic [7:0] BASE = base_val(g);
        localparam logic [7:0] STRAP_MASK = (g == IDX_CTRL) ? 8'hC0 : 8'h00;
        if (WM != 8'h00) begin : g_rw
            logic [7:0] q;
            // Hold the writable bits of this register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= BASE & WM;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_data & WM;
            end
            assign cur_flat[g*8 +: 8] = q | (BASE & ~WM) |
                                        ({strap_mode, 6'b0} & STRAP_MASK);
        end else begin : g_ro
            assign cur_flat[g*8 +: 8] = BASE | ({strap_mode, 6'b0} & STRAP_MASK);
        end
    end

    // Read port: registers in range, zero beyond the file.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < REG_COUNT; i++)
            if (rd_idx == IDX_W'(i)) rd_data = cur_flat[i*8 +: 8];
    end

    logic [7:0] ctrl_r, ena_r, enb_r, cnt_r;
    assign ctrl_r = cur_flat[IDX_CTRL*8 +: 8];
    assign ena_r  = cur_flat[IDX_ENA*8 +: 8];
    assign enb_r  = cur_flat[IDX_ENB*8 +: 8];
    assign cnt_r  = cur_flat[IDX_CNT*8 +: 8];

    assign pll_sw_en   = ctrl_r[3];
    assign pll_sw_mode = ctrl_r[2:1];
    assign out_en      = {enb_r[2], enb_r[1], ena_r[6], ena_r[5], ena_r[2], ena_r[1]};
    assign rd_count    = cnt_r[CNT_W-1:0];
endmodule

// File: rtl/smb_cfg_slave.sv
// Top level: line synchronizer, protocol engine and register file of the
// SMBus configuration slave. Assumes an external open-drain pad where
// sda_oe pulls the line low.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6C,
    parameter logic [3:0] REV_ID      = 4'h0,
    parameter logic [3:0] VEND_ID     = 4'h1,
    parameter logic [7:0] DEV_ID      = 8'hFB,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       strap_mode,
    output logic [OUT_W-1:0] out_en,
    output logic             pll_sw_en,
    output logic [1:0]       pll_sw_mode,
    output logic [CNT_W-1:0] rd_count
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       rd_data, wr_data;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             wr_en, bus_quiet;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .count_byte({{(8-CNT_W){1'b0}}, rd_count}),
        .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe), .bus_quiet(bus_quiet)
    );

    smb_cfg_regs #(.REV_ID(REV_ID), .VEND_ID(VEND_ID), .DEV_ID(DEV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .strap_mode(strap_mode),
        .rd_data(rd_data), .out_en(out_en), .pll_sw_en(pll_sw_en),
        .pll_sw_mode(pll_sw_mode), .rd_count(rd_count)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
// Checker bound to the configuration slave: bus discipline, reset values
// and write-only-through-strobe properties.
module smb_cfg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       bus_quiet,
    input logic       wr_en,
    input logic [7:0] wr_idx,
    input logic [5:0] out_en,
    input logic       pll_sw_en,
    input logic [1:0] pll_sw_mode,
    input logic [4:0] rd_count
);
    assert_reset_values_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_en == 6'h3F && rd_count == 5'd8 && !pll_sw_en &&
                          pll_sw_mode == 2'b11 && !sda_oe));

    assert_sda_hold_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    assert_quiet_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_quiet |-> !sda_oe);

    assert_oob_write_noeffect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > 8'd8) |=> ($stable(out_en) && $stable(rd_count) &&
                                      $stable(pll_sw_en) && $stable(pll_sw_mode)));

    assert_outen_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> $past(wr_en));

    assert_ctrl_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pll_sw_en, pll_sw_mode}) |-> $past(wr_en));

    assert_count_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_count) |-> $past(wr_en));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .bus_quiet(bus_quiet), .wr_en(wr_en), .wr_idx(wr_idx), .out_en(out_en),
    .pll_sw_en(pll_sw_en), .pll_sw_mode(pll_sw_mode), .rd_count(rd_count)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int Q = 12;
    localparam logic [7:0] AW = 8'hD8;
    localparam logic [7:0] AR = 8'hD9;

    // Default register contents with strap_mode = 2'b10.
    localparam logic [7:0] DEF [9] = '{8'h87, 8'hFF, 8'h0F, 8'h00, 8'h00,
                                       8'h01, 8'hFB, 8'h00, 8'h08};
    // {index, written value, expected readback}
    localparam logic [23:0] VEC [13] = '{
        24'h00FF8F, 24'h000081, 24'h010099, 24'h01FFFF, 24'h020009,
        24'h02FF0F, 24'h03FF00, 24'h050001, 24'h0600FB, 24'h075A00,
        24'h08FF1F, 24'h080808, 24'h000687};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic [1:0] strap_mode = 2'b10;
    logic sda_oe, pll_sw_en;
    logic [5:0] out_en;
    logic [1:0] pll_sw_mode;
    logic [4:0] rd_count;
    logic sda;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign sda = sda_h & ~sda_oe;

    always #5 clk = ~clk;

    smb_cfg_slave u_smb_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda), .sda_oe(sda_oe),
        .strap_mode(strap_mode), .out_en(out_en), .pll_sw_en(pll_sw_en),
        .pll_sw_mode(pll_sw_mode), .rd_count(rd_count)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q); scl_h = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
        end
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        ack = ~sda;
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        sda_h = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl_h = 1'b1; tick(Q); b = {b[6:0], sda}; scl_h = 1'b0;
        end
        tick(Q);
        sda_h = ~ack; tick(Q); scl_h = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    // acks: bit0 address, bit1 index, bit2 count, bit3.. data bytes
    task automatic write_seq(input logic [7:0] addr, input logic [7:0] idx,
                             input logic [7:0] cnt, input int n,
                             input logic [7:0] d0, input logic [7:0] d1,
                             output logic [4:0] acks);
        logic a;
        acks = '0;
        bus_start();
        send_byte(addr, a); acks[0] = a;
        send_byte(idx, a);  acks[1] = a;
        send_byte(cnt, a);  acks[2] = a;
        if (n > 0) begin send_byte(d0, a); acks[3] = a; end
        if (n > 1) begin send_byte(d1, a); acks[4] = a; end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] idx, input int n,
                            output logic [7:0] cnt, output logic [71:0] buf_o,
                            output logic [2:0] acks);
        logic a;
        logic [7:0] b;
        buf_o = '0;
        bus_start();
        send_byte(AW, a);  acks[0] = a;
        send_byte(idx, a); acks[1] = a;
        bus_start();
        send_byte(AR, a);  acks[2] = a;
        recv_byte(1'b1, cnt);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            buf_o[i*8 +: 8] = b;
        end
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] wacks;
        logic [2:0] racks;
        logic [7:0] cnt;
        logic [71:0] rbuf;
        logic [7:0] exp_cnt;

        tick(6);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state at the ports
        check("R1", "out_en", 32'(out_en), 32'h3F);
        check("R1", "pll_sw_en", 32'(pll_sw_en), 32'h0);
        check("R1", "pll_sw_mode", 32'(pll_sw_mode), 32'h3);
        check("R1", "rd_count", 32'(rd_count), 32'h8);
        check("R11", "sda_oe idle", 32'(sda_oe), 32'h0);

        // R5 default full read: count then nine registers
        read_seq(8'h00, 9, cnt, rbuf, racks);
        check("R5", "read acks", 32'(racks), 32'h7);
        check("R5", "count byte", 32'(cnt), 32'h08);
        for (int i = 0; i < 9; i++)
            check("R5", $sformatf("default reg%0d", i), 32'(rbuf[i*8 +: 8]), 32'(DEF[i]));
        tick(2);
        check("R5", "released after NACK", 32'(sda_oe), 32'h0);

        // Table walk: write one register, read it back (R3 R7 R8 R9 R10)
        exp_cnt = 8'h08;
        for (int v = 0; v < 13; v++) begin
            logic [7:0] vi, vw, ve;
            string rq;
            vi = VEC[v][23:16]; vw = VEC[v][15:8]; ve = VEC[v][7:0];
            case (vi)
                8'd0:       rq = "R7";
                8'd1, 8'd2: rq = "R8";
                8'd8:       rq = "R10";
                default:    rq = "R9";
            endcase
            write_seq(AW, vi, 8'd1, 1, vw, 8'h00, wacks);
            check("R3", $sformatf("vec%0d write acks", v), 32'(wacks[3:0]), 32'hF);
            if (vi == 8'd8) exp_cnt = ve;
            read_seq(vi, 1, cnt, rbuf, racks);
            check("R5", $sformatf("vec%0d count", v), 32'(cnt), 32'(exp_cnt));
            check(rq, $sformatf("vec%0d reg%0d", v, vi), 32'(rbuf[7:0]), 32'(ve));
        end

        // R3 two-byte write across registers 1 and 2
        write_seq(AW, 8'd1, 8'd2, 2, 8'h00, 8'h00, wacks);
        check("R3", "burst acks", 32'(wacks), 32'h1F);
        check("R3", "out_en after burst", 32'(out_en), 32'h00);

        // R7 override bits reach the ports
        write_seq(AW, 8'd0, 8'd1, 1, 8'h0A, 8'h00, wacks);
        check("R7", "pll_sw_en", 32'(pll_sw_en), 32'h1);
        check("R7", "pll_sw_mode", 32'(pll_sw_mode), 32'h1);

        // R4 surplus byte beyond the count is NACKed and dropped
        write_seq(AW, 8'd1, 8'd1, 2, 8'hFF, 8'hFF, wacks);
        check("R4", "surplus ack", 32'(wacks[4]), 32'h0);
        check("R4", "out_en", 32'(out_en), 32'h0F);

        // R2 wrong address: nothing acked, nothing written
        write_seq(8'hDA, 8'd2, 8'd1, 1, 8'hFF, 8'h00, wacks);
        check("R2", "foreign address acks", 32'(wacks[3:0]), 32'h0);
        check("R2", "out_en unchanged", 32'(out_en), 32'h0F);

        // R6 out-of-range write acked, dropped; R10 partial burst into reg8
        write_seq(AW, 8'd9, 8'd1, 1, 8'h55, 8'h00, wacks);
        check("R6", "oob write acks", 32'(wacks[3:0]), 32'hF);
        write_seq(AW, 8'd8, 8'd2, 2, 8'h02, 8'h77, wacks);
        check("R6", "burst past end acks", 32'(wacks), 32'h1F);
        check("R10", "rd_count", 32'(rd_count), 32'h02);
        read_seq(8'd7, 3, cnt, rbuf, racks);
        check("R10", "count byte follows reg8", 32'(cnt), 32'h02);
        check("R9", "reg7", 32'(rbuf[7:0]), 32'h00);
        check("R10", "reg8", 32'(rbuf[15:8]), 32'h02);
        check("R6", "reg9 reads zero", 32'(rbuf[23:16]), 32'h00);
        check("R11", "sda_oe idle at end", 32'(sda_oe), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule